// File: doc/BRIEF.md
# Gated 16-bit Timer with Prescaler

The block is a 16-bit up-counter that software reaches as two byte-wide registers, low and high. Each byte can be read and written. The counter advances on one of two sources, picked by a control bit.

- The first source is an internal enable pulse that fires once every fourth system clock.
- The second source is a rising edge on an external clock pin.

The selected source passes through a prescaler that divides it by 1, 2, 4 or 8 before it reaches the counter. A control bit decides whether the external pin passes through a two-flop synchronizer or bypasses it. Bypassing shortens the latency from pin to count.

Counting needs the run bit. When gate mode is enabled, counting also needs the external gate pin to be held low. A rollover from FFFFh to 0000h sets a sticky overflow flag, and software clears that flag by writing 0. Everything runs in the system clock domain. The internal quarter-rate source is a clock enable, not a derived clock.

Top module: `gated_timer16`

## Requirements
- R1: After reset the counter reads 0000h, the overflow flag is 0 and the control readback is 00h.
- R2: A control write stores six bits, and the readback returns them with bits 7:6 as 0. The fields are:
  - bit 0: run.
  - bit 1: source select (1 = external pin).
  - bits 3:2: prescale code (00 = /1, 01 = /2, 10 = /4, 11 = /8).
  - bit 4: synchronizer bypass (1 = bypass).
  - bit 5: gate enable.
- R3: With run set, the internal source, prescale /1 and gate mode off, the counter rises by exactly one every 4 system clocks.
- R4: Prescale code k makes the counter rise once per 2^k source events. With the internal source that is one count every 4·2^k system clocks. With the external source it is one count per 2^k rising edges.
- R5: With run clear the counter holds its value whatever the source does.
- R6: With gate enable set, the counter holds while the gate pin is 1 and counts while it is 0. The pin is sampled through two flops. With gate enable clear, the pin has no effect.
- R7: With the external source at prescale /1, each rising edge of the pin adds exactly one and falling edges add nothing.
- R8: Through the synchronizer, a pin rise becomes visible in the count after the third system clock edge. In bypass mode it becomes visible after the first edge.
- R9: A byte write loads that byte at the next clock edge and leaves the other byte unchanged. The write overrides any increment due in the same cycle.
- R10: Any write to a counter byte clears the prescaler, so the next count needs a full 2^k source events.
- R11: A rollover from FFFFh to 0000h sets the overflow flag. The flag stays set until a flag write stores 0.
- R12: A rollover in the same cycle as a flag write of 0 leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register readback |
| lo_we | input | 1 | Counter low byte write strobe |
| hi_we | input | 1 | Counter high byte write strobe |
| byte_wdata | input | 8 | Data for counter byte writes |
| cnt_lo | output | 8 | Counter low byte |
| cnt_hi | output | 8 | Counter high byte |
| flag_we | input | 1 | Overflow flag write strobe |
| flag_wdata | input | 1 | Value written to the overflow flag |
| ext_clk_in | input | 1 | External count pin, rising edge counts |
| gate_n_in | input | 1 | External gate pin, low enables counting in gate mode |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions check the following on every cycle:
- A byte write loads its byte and leaves the other byte alone.
- The overflow flag is sticky.
- A rollover sets the flag even against a clear.
- The counter is frozen when the prescaler grants no increment or the gate holds it.
- Internal and external source pulses last a single cycle.
- The prescaler empties on every byte write.

Only the bench scenarios can show the rates: one count per 4·2^k clocks, one count per 2^k edges, and the exact pin-to-count latency with and without the synchronizer. They also show the gate's effect over a whole window, and that a write cancels an increment that was due in the same cycle.

// File: rtl/gtmr_pkg.sv
// Shared types for the gated timer.
// The control word layout is fixed: bit 0 run, bit 1 source select,
// bits 3:2 prescale code, bit 4 synchronizer bypass, bit 5 gate enable.
package gtmr_pkg;

    typedef struct packed {
        logic       gate_en;   // bit 5: gate pin qualifies counting
        logic       bypass;    // bit 4: external pin skips synchronizer
        logic [1:0] ps_code;   // bits 3:2: divide by 2^code
        logic       ext_sel;   // bit 1: 1 = external pin, 0 = internal
        logic       run;       // bit 0: timer on
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/gtmr_sync.sv
// Multi-flop synchronizer for a single-bit level.
// Assumes STAGES >= 2; the output lags the input by STAGES clocks.
module gtmr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // shift the level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gtmr_ext_edge.sv
// External count pin front end: optional synchronizer, then rising-edge detect.
// Assumes the pin stays at one level for at least one system clock.
// In bypass mode the pin feeds the edge detector directly.
module gtmr_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic bypass,
    output logic rise
);

    logic synced;
    logic level;
    logic prev_q;

    gtmr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin),
        .q    (synced)
    );

    // choose between the synchronized and the raw pin level
    always_comb level = bypass ? pin : synced;

    // remember the previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;

    // R7
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/gtmr_tick_gen.sv
// Internal instruction-rate enable: one single-cycle pulse every DIV clocks.
// Assumes DIV >= 2; the pulse is a clock enable, not a clock.
module gtmr_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse
);

    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_q;

    assign pulse = (div_q == LAST);

    // free-running modulo-DIV phase counter
    always_ff @(posedge clk) begin
        if (!rst_n)     div_q <= '0;
        else if (pulse) div_q <= '0;
        else            div_q <= div_q + 1'b1;
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/gtmr_prescaler.sv
// Event prescaler: passes one of every 2^code qualified source events.
// Assumes src is a single-cycle pulse; clr takes priority over counting.
// Only events that arrive while run is high advance the prescaler.
module gtmr_prescaler #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src,
    input  logic            run,
    input  logic [PS_W-1:0] ps_code,
    input  logic            clr,
    output logic            tick
);

    localparam int PC_W = (1 << PS_W) - 1;

    logic [PC_W-1:0] pcnt_q;
    logic [PC_W-1:0] mask;

    // low bits that must all be set before an event passes
    always_comb begin
        for (int i = 0; i < PC_W; i++) mask[i] = (i < int'(ps_code));
    end

    assign tick = src & run & ((pcnt_q & mask) == mask);

    // count qualified events, clearing on any counter byte write
    always_ff @(posedge clk) begin
        if (!rst_n)          pcnt_q <= '0;
        else if (clr)        pcnt_q <= '0;
        else if (src && run) pcnt_q <= pcnt_q + 1'b1;
    end

    // R10
    psc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pcnt_q == '0);

    // R5
    psc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !clr |=> $stable(pcnt_q));

endmodule

// File: rtl/gtmr_counter.sv
// Two-byte up-counter with byte writes and a sticky overflow flag.
// Assumes inc is a single-cycle enable. A byte write wins over inc.
// A rollover wins over a flag write.
module gtmr_counter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              flag_we,
    input  logic              flag_wdata,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic              ovf
);

    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_q, flag_d;
    logic             any_wr;
    logic             wrap;

    assign any_wr = lo_we | hi_we;
    assign wrap   = inc & ~any_wr & (&cnt_q);

    // next count: increment unless a byte write overrides it
    always_comb begin
        cnt_d = cnt_q;
        if (inc && !any_wr) cnt_d = cnt_q + 1'b1;
        if (lo_we) cnt_d[BYTE_W-1:0]     = wdata;
        if (hi_we) cnt_d[CNT_W-1:BYTE_W] = wdata;
    end

    // next flag: rollover first, then software write
    always_comb begin
        if (wrap)         flag_d = 1'b1;
        else if (flag_we) flag_d = flag_wdata;
        else              flag_d = flag_q;
    end

    // register count and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    assign cnt_lo = cnt_q[BYTE_W-1:0];
    assign cnt_hi = cnt_q[CNT_W-1:BYTE_W];
    assign ovf    = flag_q;

    // R9
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> cnt_lo == $past(wdata));

    // R9
    hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we && !hi_we |=> cnt_hi == $past(cnt_hi));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc && !any_wr |=> $stable(cnt_q));

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !flag_we |=> ovf);

    // R12
    rollover_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !any_wr && (cnt_q == '1) |=> ovf && (cnt_q == '0));

endmodule

// File: rtl/gated_timer16.sv
// Gated 16-bit timer top: control register, source select, gate and prescale.
// Assumes BYTE_W >= CTRL_W. Every input is sampled on the system clock.
// The gate pin is always synchronized; the count pin optionally.
module gated_timer16 #(
    parameter int BYTE_W      = 8,
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int PS_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [BYTE_W-1:0] ctrl_wdata,
    output logic [BYTE_W-1:0] ctrl_rdata,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] byte_wdata,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    input  logic              flag_we,
    input  logic              flag_wdata,
    input  logic              ext_clk_in,
    input  logic              gate_n_in,
    output logic              ovf_flag
);
    import gtmr_pkg::*;

    localparam int PAD_W = BYTE_W - CTRL_W;

    ctrl_t ctrl_q;
    logic  int_pulse;
    logic  ext_rise;
    logic  gate_lvl;
    logic  src_pulse;
    logic  run_ok;
    logic  inc;

    // control register write
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata[CTRL_W-1:0]);
    end

    assign ctrl_rdata = {{PAD_W{1'b0}}, ctrl_q};

    gtmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .pulse(int_pulse)
    );

    gtmr_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk_in),
        .bypass(ctrl_q.bypass),
        .rise  (ext_rise)
    );

    gtmr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_gate_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (gate_n_in),
        .q    (gate_lvl)
    );

    // pick the source and qualify it by run and gate
    always_comb begin
        src_pulse = ctrl_q.ext_sel ? ext_rise : int_pulse;
        run_ok    = ctrl_q.run & (~ctrl_q.gate_en | ~gate_lvl);
    end

    gtmr_prescaler #(.PS_W(PS_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src_pulse),
        .run    (run_ok),
        .ps_code(ctrl_q.ps_code),
        .clr    (lo_we | hi_we),
        .tick   (inc)
    );

    gtmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (inc),
        .lo_we     (lo_we),
        .hi_we     (hi_we),
        .wdata     (byte_wdata),
        .flag_we   (flag_we),
        .flag_wdata(flag_wdata),
        .cnt_lo    (cnt_lo),
        .cnt_hi    (cnt_hi),
        .ovf       (ovf_flag)
    );

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_rdata == {{PAD_W{1'b0}}, $past(ctrl_wdata[CTRL_W-1:0])});

    // R6
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.gate_en && gate_lvl && !lo_we && !hi_we |=> $stable({cnt_hi, cnt_lo}));

endmodule

// File: tb/gated_timer16_bench.sv
// Directed bench for the gated timer: one task per scenario.
module gated_timer16_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       lo_we = 1'b0;
    logic       hi_we = 1'b0;
    logic [7:0] byte_wdata = '0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       flag_we = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic       gate_n_in = 1'b1;
    logic       ovf_flag;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    gated_timer16 u_gated_timer16 (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .lo_we(lo_we), .hi_we(hi_we), .byte_wdata(byte_wdata),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .ext_clk_in(ext_clk_in), .gate_n_in(gate_n_in), .ovf_flag(ovf_flag)
    );

    function automatic logic [15:0] cnt();
        return {cnt_hi, cnt_lo};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        cyc(1);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_lo(input logic [7:0] v);
        lo_we = 1'b1; byte_wdata = v;
        cyc(1);
        lo_we = 1'b0;
    endtask

    task automatic wr_hi(input logic [7:0] v);
        hi_we = 1'b1; byte_wdata = v;
        cyc(1);
        hi_we = 1'b0;
    endtask

    task automatic wr_flag(input logic v);
        flag_we = 1'b1; flag_wdata = v;
        cyc(1);
        flag_we = 1'b0;
    endtask

    task automatic pulse_ext(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1'b1; cyc(half);
            ext_clk_in = 1'b0; cyc(half);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        chk("R1 count", cnt(), 16'h0000);
        chk("R1 flag", ovf_flag, 1'b0);
        chk("R1 ctrl", ctrl_rdata, 8'h00);
    endtask

    // R2: control readback masks the unused top bits
    task automatic t_ctrl();
        set_ctrl(8'hFF);
        chk("R2 readback FF", ctrl_rdata, 8'h3F);
        set_ctrl(8'h2C);
        chk("R2 readback 2C", ctrl_rdata, 8'h2C);
        set_ctrl(8'h00);
    endtask

    // R3 and R4: internal rate for each prescale code
    task automatic t_int_rate();
        for (int k = 0; k < 4; k++) begin
            logic [15:0] a;
            int per;
            per = 4 * (1 << k);
            set_ctrl(8'((k << 2) | 1));
            cyc(per);
            a = cnt();
            cyc(per * 5);
            chk(k == 0 ? "R3 internal /1 rate" : "R4 internal prescaled rate",
                16'(cnt() - a), 16'd5);
        end
    endtask

    // R5: run clear freezes the count, with either source
    task automatic t_off();
        logic [15:0] a;
        set_ctrl(8'h00);
        cyc(2);
        a = cnt();
        cyc(40);
        chk("R5 off internal", cnt(), a);
        set_ctrl(8'h12);
        pulse_ext(4, 2);
        chk("R5 off external", cnt(), a);
    endtask

    // R6: gate pin high blocks, low counts, ignored when gate mode is off
    task automatic t_gate();
        logic [15:0] a;
        set_ctrl(8'h21);
        gate_n_in = 1'b1; cyc(6);
        a = cnt(); cyc(40);
        chk("R6 gate high holds", 16'(cnt() - a), 16'd0);
        gate_n_in = 1'b0; cyc(6);
        a = cnt(); cyc(40);
        chk("R6 gate low counts", 16'(cnt() - a), 16'd10);
        gate_n_in = 1'b1;
        set_ctrl(8'h01); cyc(6);
        a = cnt(); cyc(40);
        chk("R6 gate ignored when disabled", 16'(cnt() - a), 16'd10);
    endtask

    // R7 and R4: external edges through the synchronizer
    task automatic t_ext();
        set_ctrl(8'h03);
        wr_lo(8'h00); wr_hi(8'h00);
        pulse_ext(6, 4);
        cyc(4);
        chk("R7 six rising edges", cnt(), 16'd6);
        set_ctrl(8'h0B);
        wr_lo(8'h00);
        pulse_ext(10, 4);
        cyc(4);
        chk("R4 external /4", cnt(), 16'd2);
    endtask

    // R8: pin-to-count latency with and without synchronizer
    task automatic t_latency();
        set_ctrl(8'h03);
        wr_lo(8'h00); wr_hi(8'h00);
        cyc(2);
        ext_clk_in = 1'b1;
        cyc(1); chk("R8 sync edge 1", cnt(), 16'd0);
        cyc(1); chk("R8 sync edge 2", cnt(), 16'd0);
        cyc(1); chk("R8 sync edge 3", cnt(), 16'd1);
        ext_clk_in = 1'b0; cyc(6);
        set_ctrl(8'h13); cyc(2);
        ext_clk_in = 1'b1;
        cyc(1); chk("R8 bypass edge 1", cnt(), 16'd2);
        ext_clk_in = 1'b0; cyc(4);
    endtask

    // R9: byte writes load one byte and override an increment
    task automatic t_write();
        set_ctrl(8'h00);
        wr_lo(8'h00); wr_hi(8'h56);
        wr_lo(8'h34);
        chk("R9 low write keeps high", cnt(), 16'h5634);
        wr_hi(8'h12);
        chk("R9 high write keeps low", cnt(), 16'h1234);
        set_ctrl(8'h13);
        wr_hi(8'h00); wr_lo(8'hFF);
        cyc(2);
        lo_we = 1'b1; byte_wdata = 8'h10; ext_clk_in = 1'b1;
        cyc(1);
        lo_we = 1'b0;
        chk("R9 write overrides increment", cnt(), 16'h0010);
        ext_clk_in = 1'b0; cyc(3);
    endtask

    // R10: byte write restarts the prescaler
    task automatic t_psclr();
        set_ctrl(8'h1F);
        wr_lo(8'h00); wr_hi(8'h00);
        pulse_ext(5, 2);
        chk("R10 five of eight", cnt(), 16'd0);
        wr_lo(8'h00);
        pulse_ext(7, 2);
        chk("R10 seven after clear", cnt(), 16'd0);
        pulse_ext(1, 2);
        chk("R10 eighth after clear", cnt(), 16'd1);
    endtask

    // R11: rollover sets the flag, which stays until cleared
    task automatic t_ovf();
        set_ctrl(8'h13);
        wr_lo(8'hFF); wr_hi(8'hFF);
        ext_clk_in = 1'b1; cyc(1);
        chk("R11 rollover count", cnt(), 16'h0000);
        chk("R11 flag set", ovf_flag, 1'b1);
        ext_clk_in = 1'b0; cyc(2);
        pulse_ext(3, 2);
        chk("R11 flag sticky", ovf_flag, 1'b1);
        wr_flag(1'b0);
        chk("R11 flag cleared", ovf_flag, 1'b0);
    endtask

    // R12: rollover beats a simultaneous clear
    task automatic t_race();
        set_ctrl(8'h13);
        wr_lo(8'hFF); wr_hi(8'hFF);
        cyc(1);
        ext_clk_in = 1'b1; flag_we = 1'b1; flag_wdata = 1'b0;
        cyc(1);
        flag_we = 1'b0;
        chk("R12 rollover wins flag", ovf_flag, 1'b1);
        chk("R12 rollover count", cnt(), 16'h0000);
        ext_clk_in = 1'b0; cyc(2);
        wr_flag(1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_ctrl();
        t_int_rate();
        t_off();
        t_gate();
        t_ext();
        t_latency();
        t_write();
        t_psclr();
        t_ovf();
        t_race();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule